// File: doc/BRIEF.md
# MAC/VLAN Table Search Engine

This block walks a lookup table of 68-bit typed entries one slot per cycle and reports where the first entry that meets a chosen condition sits. Each slot holds a 2-bit kind (free, address, VLAN, or VLAN plus address), a 12-bit VLAN ID, a 48-bit MAC address and, for address entries, a 2-bit unicast class. The table itself lives outside the block and is reached through a synchronous read port with one cycle of latency.

A caller presents a command (operation code, MAC and VLAN ID) while the engine reports idle. Four searches are available: find an address entry by MAC and VLAN ID, find a VLAN entry by ID, find the first free slot, and find the first unicast address entry that may be replaced. The engine reads slots in ascending order from slot 0. It stops at the first hit, or after the last slot. It then raises a one-cycle done pulse with a found flag and the slot index.

Top module: `tbl_search_engine`

## Requirements
- R1: After reset, idle is high, and done, found and tbl_rd_en are low.
- R2: Operation code 0 (address match) hits a slot whose kind (bits 61:60) is 1 or 3, whose VLAN ID (bits 59:48) equals cmd_vid and whose MAC (bits 47:0, first octet in 47:40) equals cmd_mac in all 48 bits.
- R3: Operation code 1 (VLAN match) hits a slot whose kind is 2 and whose VLAN ID equals cmd_vid. Address and VLAN-plus-address slots never match it.
- R4: Operation code 2 (free search) hits a slot whose kind is 0.
- R5: Operation code 3 (replaceable search) hits a slot whose kind is 1 or 3, whose multicast bit 40 is clear, and whose unicast class (bits 63:62) is 1 (untouched) or 3 (touched). Class 0 (persistent) and class 2 (vendor prefix) are skipped.
- R6: Slots are read one per cycle, from index 0 upward with consecutive addresses. The result is the lowest index that satisfies the condition.
- R7: The command is accepted on clock edge E0. If the hit is at index k, done is high for exactly one cycle after edge E(k+2), with found high and result_idx equal to k.
- R8: When no slot satisfies the condition, done pulses after edge E(DEPTH+1) with found low.
- R9: A command presented while idle is low is ignored. It produces no done pulse and does not change the result of the search in progress. idle returns high together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken only while idle |
| cmd_op | input | 2 | 0 address match, 1 VLAN match, 2 free, 3 replaceable |
| cmd_mac | input | 48 | MAC key for address match |
| cmd_vid | input | 12 | VLAN ID key |
| idle | output | 1 | Engine can take a command |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_addr | output | IDX_W | Table slot being read |
| tbl_rd_data | input | 68 | Slot contents, valid the cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A slot matched (valid with done) |
| result_idx | output | IDX_W | Lowest matching slot (valid with done and found) |

## Verification
The first table read is issued in the cycle after the accepting edge. A hit at slot k is therefore reported in the cycle that follows the (k+2)-th edge after acceptance, and a miss after edge DEPTH+1. The bench drives and samples on the falling edge and counts rising edges from acceptance. It requires done to appear exactly at the computed count, then requires it to be low in the following cycles. The expected slot and latency come from the bench's own scan of its table model, run from the top slot downward. Sweeps cover every slot position for the free and replaceable searches, every kind, class and multicast combination, duplicate keys, and commands injected during a scan.

// File: rtl/srch_pkg.sv
package srch_pkg;
  localparam int ENTRY_W  = 68;
  localparam int MAC_W    = 48;
  localparam int VID_W    = 12;
  localparam int MAC_LO   = 0;
  localparam int MCAST_B  = 40;
  localparam int VID_LO   = 48;
  localparam int KIND_LO  = 60;
  localparam int UCLS_LO  = 62;

  typedef enum logic [1:0] {
    KIND_FREE      = 2'd0,
    KIND_ADDR      = 2'd1,
    KIND_VLAN      = 2'd2,
    KIND_VLAN_ADDR = 2'd3
  } entry_kind_e;

  typedef enum logic [1:0] {
    UCLS_PINNED    = 2'd0,
    UCLS_FRESH     = 2'd1,
    UCLS_PREFIX    = 2'd2,
    UCLS_USED      = 2'd3
  } ucast_cls_e;

  typedef enum logic [1:0] {
    OP_MATCH_ADDR  = 2'd0,
    OP_MATCH_VLAN  = 2'd1,
    OP_FIND_FREE   = 2'd2,
    OP_FIND_REPL   = 2'd3
  } srch_op_e;

  typedef struct packed {
    srch_op_e         op;
    logic [VID_W-1:0] vid;
    logic [MAC_W-1:0] mac;
  } srch_cmd_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } srch_state_e;
endpackage

// File: rtl/srch_pred.sv
module srch_pred
  import srch_pkg::*;
(
  input  srch_cmd_t            cmd,
  input  logic [ENTRY_W-1:0]   entry,
  output logic                 hit
);
  entry_kind_e kind;
  ucast_cls_e  ucls;
  logic        is_addr;
  logic        vid_eq;
  logic        mac_eq;
  logic        mcast;
  logic        replaceable;
  logic        unused_hi;

  always_comb begin
    kind        = entry_kind_e'(entry[KIND_LO +: 2]);
    ucls        = ucast_cls_e'(entry[UCLS_LO +: 2]);
    is_addr     = (kind == KIND_ADDR) || (kind == KIND_VLAN_ADDR);
    vid_eq      = (entry[VID_LO +: VID_W] == cmd.vid);
    mac_eq      = (entry[MAC_LO +: MAC_W] == cmd.mac);
    mcast       = entry[MCAST_B];
    replaceable = (ucls == UCLS_FRESH) || (ucls == UCLS_USED);
    case (cmd.op)
      OP_MATCH_ADDR: hit = is_addr && vid_eq && mac_eq;
      OP_MATCH_VLAN: hit = (kind == KIND_VLAN) && vid_eq;
      OP_FIND_FREE:  hit = (kind == KIND_FREE);
      default:       hit = is_addr && !mcast && replaceable;
    endcase
  end

  assign unused_hi = ^entry[ENTRY_W-1:UCLS_LO+2];
endmodule

// File: rtl/srch_issue.sv
module srch_issue #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             scan,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr
);
  localparam logic [IDX_W:0] END_CNT = (IDX_W+1)'(DEPTH);

  logic [IDX_W:0] cnt_q;
  logic [IDX_W:0] cnt_d;
  logic           cnt_en;

  always_comb begin
    rd_en  = scan && (cnt_q < END_CNT);
    cnt_en = start || rd_en;
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign rd_addr = cnt_q[IDX_W-1:0];
endmodule

// File: rtl/tbl_search_engine.sv
module tbl_search_engine
  import srch_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [47:0]        cmd_mac,
  input  logic [11:0]        cmd_vid,
  output logic               idle,
  output logic               tbl_rd_en,
  output logic [IDX_W-1:0]   tbl_rd_addr,
  input  logic [67:0]        tbl_rd_data,
  output logic               done,
  output logic               found,
  output logic [IDX_W-1:0]   result_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  srch_state_e      state_q, state_d;
  srch_cmd_t        cmd_q;
  logic             start;
  logic             scan;
  logic             chk_vld_q, chk_vld_d;
  logic [IDX_W-1:0] chk_idx_q;
  logic             pred_hit;
  logic             hit;
  logic             exhausted;
  logic             finish;
  logic             done_q, found_q;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign scan  = (state_q == ST_SCAN);
  assign start = (state_q == ST_IDLE) && cmd_valid;

  srch_issue #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_issue (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .scan    (scan),
    .rd_en   (tbl_rd_en),
    .rd_addr (tbl_rd_addr)
  );

  srch_pred u_pred (
    .cmd   (cmd_q),
    .entry (tbl_rd_data),
    .hit   (pred_hit)
  );

  always_comb begin
    hit       = chk_vld_q && pred_hit;
    exhausted = chk_vld_q && !pred_hit && (chk_idx_q == LAST_IDX);
    finish    = hit || exhausted;
    chk_vld_d = tbl_rd_en && !finish;
    idx_d     = hit ? chk_idx_q : '0;
    state_d   = state_q;
    case (state_q)
      ST_IDLE: if (start)  state_d = ST_SCAN;
      default: if (finish) state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      chk_vld_q <= 1'b0;
      chk_idx_q <= '0;
      done_q    <= 1'b0;
      found_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      chk_vld_q <= chk_vld_d;
      chk_idx_q <= tbl_rd_addr;
      done_q    <= finish;
      found_q   <= hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (start)  cmd_q <= '{op: srch_op_e'(cmd_op), vid: cmd_vid, mac: cmd_mac};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (finish) idx_q <= idx_d;
  end

  assign idle       = (state_q == ST_IDLE);
  assign done       = done_q;
  assign found      = found_q;
  assign result_idx = idx_q;
endmodule

// File: rtl/srch_checker.sv
module srch_checker #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             idle,
  input logic             tbl_rd_en,
  input logic [IDX_W-1:0] tbl_rd_addr,
  input logic             done,
  input logic             found,
  input logic [IDX_W-1:0] result_idx
);
  assert_idle_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !tbl_rd_en);

  assert_first_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbl_rd_en) |-> (tbl_rd_addr == '0));

  assert_reads_ascend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_en && $past(tbl_rd_en)) |-> (tbl_rd_addr == $past(tbl_rd_addr) + 1'b1));

  assert_hit_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (result_idx == $past(tbl_rd_addr, 2)));

  assert_found_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> done);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_returns_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (idle && !tbl_rd_en));

  assert_accept_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_valid) |=> (!idle && tbl_rd_en));
endmodule

bind tbl_search_engine srch_checker #(.IDX_W(IDX_W)) u_srch_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .idle        (idle),
  .tbl_rd_en   (tbl_rd_en),
  .tbl_rd_addr (tbl_rd_addr),
  .done        (done),
  .found       (found),
  .result_idx  (result_idx)
);

// File: tb/tbl_search_engine_test.sv
module tbl_search_engine_test;
  localparam int DEPTH = 16;
  localparam int IDX_W = 4;

  logic             clk;
  logic             rst_n;
  logic             cmd_valid;
  logic [1:0]       cmd_op;
  logic [47:0]      cmd_mac;
  logic [11:0]      cmd_vid;
  logic             idle;
  logic             tbl_rd_en;
  logic [IDX_W-1:0] tbl_rd_addr;
  logic [67:0]      tbl_rd_data;
  logic             done;
  logic             found;
  logic [IDX_W-1:0] result_idx;

  logic [67:0] mem [DEPTH];
  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  tbl_search_engine #(.DEPTH(DEPTH)) uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) if (tbl_rd_en) tbl_rd_data <= mem[tbl_rd_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [67:0] mk(input logic [1:0] kind, input logic [1:0] ucls,
                                     input logic [11:0] vid, input logic [47:0] mac);
    return {4'h0, ucls, kind, vid, mac};
  endfunction

  function automatic bit bench_pred(input logic [1:0] op, input logic [47:0] mac,
                                    input logic [11:0] vid, input logic [67:0] e);
    case (op)
      2'd0:    return e[60] && (e[59:48] == vid) && (e[47:0] == mac);
      2'd1:    return (e[61:60] == 2'd2) && (e[59:48] == vid);
      2'd2:    return (e[61:60] == 2'd0);
      default: return e[60] && !e[40] && e[62];
    endcase
  endfunction

  task automatic ref_search(input logic [1:0] op, input logic [47:0] mac, input logic [11:0] vid,
                            output bit f, output int idx);
    f = 0; idx = 0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (bench_pred(op, mac, vid, mem[i])) begin f = 1; idx = i; end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [47:0] mac, input logic [11:0] vid,
                         input bit inject, input string req);
    bit ef; int ei; int c; bit seen; int exp_c; int watch;
    ref_search(op, mac, vid, ef, ei);
    exp_c = ef ? ei + 2 : DEPTH + 1;
    @(negedge clk);
    chk(idle === 1'b1, "R9 idle before command", idle, 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_mac = mac; cmd_vid = vid;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(idle === 1'b0, "R9 busy after accept", idle, 0);
    c = 0; seen = 0;
    while (!seen && c < DEPTH + 4) begin
      @(posedge clk);
      @(negedge clk);
      c++;
      if (inject && c == 2) begin
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_mac = '0; cmd_vid = '0;
      end else begin
        cmd_valid = 1'b0;
      end
      if (done === 1'b1) seen = 1;
    end
    cmd_valid = 1'b0;
    chk(seen && c == exp_c, ef ? "R7 done latency" : "R8 miss latency", c, exp_c);
    chk(found === ef, {req, " found flag"}, found, ef);
    if (ef) chk(result_idx === IDX_W'(ei), {req, " R6 lowest index"}, result_idx, ei);
    chk(idle === 1'b1, "R9 idle with done", idle, 1);
    watch = inject ? DEPTH + 4 : 1;
    seen = 0;
    for (int k = 0; k < watch; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done !== 1'b0) seen = 1;
    end
    chk(!seen, inject ? "R9 injected command ignored" : "R9 single done pulse", seen, 0);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_mac = '0; cmd_vid = '0;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(idle === 1'b1, "R1 idle in reset", idle, 1);
    chk(done === 1'b0 && found === 1'b0, "R1 done/found in reset", {done, found}, 0);
    chk(tbl_rd_en === 1'b0, "R1 no read in reset", tbl_rd_en, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(idle === 1'b1 && done === 1'b0 && tbl_rd_en === 1'b0, "R1 state after reset", idle, 1);

    // Mixed table with duplicate keys: kind cycles, VLAN IDs and MACs repeat
    for (int i = 0; i < DEPTH; i++)
      mem[i] = mk(2'(i % 4), 2'(i % 3), 12'((i * 3) % 8), {8'h02, 32'h0, 8'((i * 7) % 5)});

    // R2: every slot's own key, then near misses
    for (int i = 0; i < DEPTH; i++)
      run_cmd(2'd0, mem[i][47:0], mem[i][59:48], 1'b0, "R2");
    run_cmd(2'd0, mem[1][47:0] ^ 48'h8000_0000_0000, mem[1][59:48], 1'b0, "R2 msb differs");
    run_cmd(2'd0, mem[1][47:0] ^ 48'h1, mem[1][59:48], 1'b0, "R2 lsb differs");
    run_cmd(2'd0, mem[1][47:0], mem[1][59:48] ^ 12'h800, 1'b0, "R2 vid differs");

    // R3: sweep VLAN IDs, including IDs only held by address slots
    for (int v = 0; v < 10; v++)
      run_cmd(2'd1, 48'h0, 12'(v), 1'b0, "R3");

    // R4: single free slot at every position, then none
    for (int p = 0; p < DEPTH; p++) begin
      for (int i = 0; i < DEPTH; i++) mem[i] = mk(2'd2, 2'd0, 12'(i), 48'h0);
      mem[p] = mk(2'd0, 2'd1, 12'h5, 48'h1);
      run_cmd(2'd2, 48'h0, 12'h0, 1'b0, "R4");
    end
    for (int i = 0; i < DEPTH; i++) mem[i] = mk(2'd1, 2'd0, 12'(i), 48'h0);
    run_cmd(2'd2, 48'h0, 12'h0, 1'b0, "R4 none free");

    // R5: every kind x class x multicast combination at a moving slot
    for (int cmb = 0; cmb < 32; cmb++) begin
      for (int i = 0; i < DEPTH; i++) mem[i] = mk(2'd1, 2'd0, 12'h0, 48'h0);
      mem[cmb % DEPTH] = mk(2'(cmb % 4), 2'((cmb / 4) % 4), 12'h3,
                            {7'h0, 1'((cmb / 16) % 2), 40'h12});
      run_cmd(2'd3, 48'h0, 12'h0, 1'b0, "R5");
    end
    // R5 with several candidates: lowest wins
    for (int i = 0; i < DEPTH; i++) mem[i] = mk(2'd3, 2'(i % 4), 12'h0, {7'h0, 1'(i < 7), 40'h0});
    run_cmd(2'd3, 48'h0, 12'h0, 1'b0, "R5 first of many");

    // R9: command injected mid-scan while a long miss runs
    for (int i = 0; i < DEPTH; i++) mem[i] = mk(2'd2, 2'd0, 12'(i), 48'h0);
    mem[DEPTH - 1] = mk(2'd0, 2'd0, 12'h0, 48'h0);
    run_cmd(2'd0, 48'hABCD, 12'h7, 1'b1, "R9 miss with injection");
    run_cmd(2'd2, 48'h0, 12'h0, 1'b1, "R9 last-slot hit with injection");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule